// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Core

This block models the device side of a 1 Kbit serial EEPROM on a fast system clock. It watches a chip-select pin, a serial clock pin and a serial data-in pin, and drives one serial data-out pin together with a separate enable that marks when that pin is meaningful. A strap pin picks one of two views of the same storage: 64 words of 16 bits, or 128 bytes of 8 bits. The pins are synchronised, and serial clock edges are detected against the system clock. The serial clock therefore has to stay well below the system clock, with each phase several system cycles long.

A host frames each instruction with chip select. The frame holds a start bit, a two-bit operation code and an address. The block can read with sequential streaming, program a single word, erase a single word, erase the whole array, fill the whole array, and open or close a write-enable latch. Programming is self-timed: the array is updated once and a parameterised cycle counter then holds the core busy. While the core is busy it reports ready/busy on the data-out pin whenever chip select is high.

The serial pins carry no valid/ready handshake. The host owns the serial clock, so there is no back-pressure. The host learns that a programming cycle has finished only by polling the ready/busy level.

Top module: `uwire_eeprom_core`

## Requirements
- R1: An instruction can begin only when chip select rises while the serial clock is low. If chip select rises while the serial clock is high, the whole frame is ignored. Zeros on data-in before the first 1 are skipped, and the first serial clock rising edge that samples data-in = 1 is the start bit.
- R2: After the start bit, two op bits are shifted in MSB first, followed by the address MSB first. The address is 6 bits when org_i = 1 (16-bit words) and 7 bits when org_i = 0 (bytes). Op 10 reads, 01 programs a word, 11 erases a word, and 00 is an extension. For the extension, the two top address bits select the action: 11 opens the write latch, 00 closes it, 10 erases everything and 01 fills everything.
- R3: A read drives a single 0 on dout_o right after the last address bit is sampled. After that the addressed word follows MSB first. dout_o changes only after rising serial clock edges.
- R4: While chip select stays high, a read continues with the next address and no extra 0 bit. The address wraps from 63 to 0 in word view and from 127 to 0 in byte view.
- R5: In byte view, byte address b maps to word b>>1. It is the upper half of that word when b[0] = 1 and the lower half when b[0] = 0.
- R6: The write latch is clear after reset. Word program, word erase, erase-all and fill-all have no effect while the latch is clear. Reads work whatever the latch holds.
- R7: A word program replaces the addressed word or byte. A word erase sets it to all ones. Erase-all sets every location to all ones. Fill-all sets every cell to the bitwise AND of its old contents and the data word. In byte view, the data byte is used for both halves of each word.
- R8: Programming starts when chip select falls after the last data bit (for word program and fill-all) or after the last address bit (for word erase and erase-all). A further serial clock rising edge before that fall cancels the instruction, and so does a fall before the frame is complete.
- R9: If chip select is raised while the core is busy, dout_o is 0 until the cycle ends and then 1. In this state, input bits are ignored until the cycle ends. A start bit decoded after that returns dout_o to 0.
- R10: After reset the array holds all ones, and dout_o and dout_oe_o are 0. dout_oe_o follows the synchronised chip select, and dout_o is 0 while the core idles with chip select low.
- R11: A programming cycle keeps the core busy for PROG_CYCLES system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Chip select pin, active high, asynchronous |
| sclk_i | input | 1 | Serial clock pin, asynchronous |
| din_i | input | 1 | Serial data in, sampled on serial clock rising edges |
| org_i | input | 1 | View select: 1 = 64 x 16, 0 = 128 x 8 |
| dout_o | output | 1 | Serial data out or ready/busy level |
| dout_oe_o | output | 1 | High while dout_o is meaningful (chip select high) |

## Verification
Two functions can fall in the same stretch of time. The programming timer may expire while a host holds chip select high and keeps clocking in an instruction in status mode. The bench provokes this by raising chip select right after starting a programming cycle, checking the busy level, and shifting in a complete latch-close instruction while the cycle is still running. It then checks that ready appears after the cycle, that a new start bit drops the pin to 0, and that the latch-close instruction sent during the busy time had no effect, because a following word program still lands.

// File: rtl/uw_pkg.sv
package uw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_HUNT, ST_CMD, ST_DATA, ST_ARMED, ST_READ, ST_IGNORE, ST_STATUS
  } uw_state_e;

  typedef enum logic [2:0] {
    MOP_NONE, MOP_WRITE, MOP_ERASE, MOP_ERAL, MOP_WRAL
  } uw_mop_e;

  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_ERASE = 2'b11;
  localparam logic [1:0] OPC_EXT   = 2'b00;
  localparam logic [1:0] EXT_WEN   = 2'b11;
  localparam logic [1:0] EXT_WDS   = 2'b00;
  localparam logic [1:0] EXT_ERAL  = 2'b10;
  localparam logic [1:0] EXT_WRAL  = 2'b01;
endpackage

// File: rtl/uw_sync.sv
module uw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic a_i,
  output logic lvl_o
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe[0] <= 1'b0;
    else        pipe[0] <= a_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[g] <= 1'b0;
      else        pipe[g] <= pipe[g-1];
    end
  end

  assign lvl_o = pipe[STAGES-1];
endmodule

// File: rtl/uw_prog_timer.sv
module uw_prog_timer #(
  parameter int CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  localparam int CNTW = $clog2(CYCLES + 1);
  logic [CNTW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (start_i)       cnt_q <= CNTW'(CYCLES);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/uw_array.sv
module uw_array import uw_pkg::*; #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         org_i,
  input  logic [$clog2(DEPTH):0]       rd_addr_i,
  output logic [WORD_W-1:0]            rd_data_o,
  input  uw_mop_e                      op_i,
  input  logic [$clog2(DEPTH):0]       wr_addr_i,
  input  logic [WORD_W-1:0]            wr_data_i
);
  localparam int HALF = WORD_W / 2;
  localparam int AW16 = $clog2(DEPTH);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW16-1:0]   rd_idx, wr_idx;
  logic [WORD_W-1:0] rd_word, fill_pat;

  assign rd_idx  = org_i ? rd_addr_i[AW16-1:0] : rd_addr_i[AW16:1];
  assign wr_idx  = org_i ? wr_addr_i[AW16-1:0] : wr_addr_i[AW16:1];
  assign rd_word = mem[rd_idx];
  assign rd_data_o = org_i ? rd_word
                   : {{HALF{1'b0}}, (rd_addr_i[0] ? rd_word[WORD_W-1:HALF] : rd_word[HALF-1:0])};
  assign fill_pat = org_i ? wr_data_i : {2{wr_data_i[HALF-1:0]}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else begin
      unique case (op_i)
        MOP_WRITE: begin
          if (org_i)             mem[wr_idx] <= wr_data_i;
          else if (wr_addr_i[0]) mem[wr_idx][WORD_W-1:HALF] <= wr_data_i[HALF-1:0];
          else                   mem[wr_idx][HALF-1:0] <= wr_data_i[HALF-1:0];
        end
        MOP_ERASE: begin
          if (org_i)             mem[wr_idx] <= '1;
          else if (wr_addr_i[0]) mem[wr_idx][WORD_W-1:HALF] <= '1;
          else                   mem[wr_idx][HALF-1:0] <= '1;
        end
        MOP_ERAL: for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        MOP_WRAL: for (int i = 0; i < DEPTH; i++) mem[i] <= mem[i] & fill_pat;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/uwire_eeprom_core.sv
module uwire_eeprom_core import uw_pkg::*; #(
  parameter int WORD_W      = 16,
  parameter int DEPTH       = 64,
  parameter int PROG_CYCLES = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_i,
  input  logic sclk_i,
  input  logic din_i,
  input  logic org_i,
  output logic dout_o,
  output logic dout_oe_o
);
  localparam int BYTE_W = WORD_W / 2;
  localparam int AW16   = $clog2(DEPTH);
  localparam int AW8    = AW16 + 1;
  localparam int CMD_W  = AW8 + 2;
  localparam int CW     = $clog2(WORD_W + CMD_W + 1);

  logic s_lvl, c_lvl, d_lvl, s_prev, c_prev, s_rise, s_fall, c_rise;
  uw_sync #(.STAGES(SYNC_STAGES)) u_sync_s (.clk(clk), .rst_n(rst_n), .a_i(sel_i),  .lvl_o(s_lvl));
  uw_sync #(.STAGES(SYNC_STAGES)) u_sync_c (.clk(clk), .rst_n(rst_n), .a_i(sclk_i), .lvl_o(c_lvl));
  uw_sync #(.STAGES(SYNC_STAGES)) u_sync_d (.clk(clk), .rst_n(rst_n), .a_i(din_i),  .lvl_o(d_lvl));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin s_prev <= 1'b0; c_prev <= 1'b0; end
    else        begin s_prev <= s_lvl; c_prev <= c_lvl; end
  end
  assign s_rise = s_lvl & ~s_prev;
  assign s_fall = ~s_lvl & s_prev;
  assign c_rise = c_lvl & ~c_prev;

  uw_state_e         state_q;
  uw_mop_e           mop_q, pend_q;
  logic              wen_q, first_q, dout_q, busy;
  logic [CMD_W-2:0]  shreg_q;
  logic [CMD_W-1:0]  cmd_nxt;
  logic [CW-1:0]     bcnt_q, ocnt_q, aw_c, dw_c;
  logic [AW8-1:0]    addr_q, addr_next, addr_mask, dec_addr, rd_addr;
  logic [1:0]        dec_op, dec_ext;
  logic [WORD_W-1:0] dsr_q, osr_q, rd_data;

  // Per-view field widths and decode slices.
  assign aw_c      = org_i ? CW'(AW16) : CW'(AW8);
  assign dw_c      = org_i ? CW'(WORD_W) : CW'(BYTE_W);
  assign addr_mask = org_i ? {1'b0, {AW16{1'b1}}} : {AW8{1'b1}};
  assign addr_next = (addr_q + 1'b1) & addr_mask;
  assign cmd_nxt   = {shreg_q, d_lvl};
  assign dec_op    = org_i ? cmd_nxt[AW16+1:AW16]  : cmd_nxt[AW8+1:AW8];
  assign dec_ext   = org_i ? cmd_nxt[AW16-1:AW16-2] : cmd_nxt[AW8-1:AW8-2];
  assign dec_addr  = org_i ? {1'b0, cmd_nxt[AW16-1:0]} : cmd_nxt[AW8-1:0];
  assign rd_addr   = first_q ? addr_q : addr_next;

  uw_array #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_array (
    .clk(clk), .rst_n(rst_n), .org_i(org_i),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .op_i(mop_q), .wr_addr_i(addr_q), .wr_data_i(dsr_q)
  );

  uw_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_i(mop_q != MOP_NONE), .busy_o(busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;  mop_q <= MOP_NONE; pend_q <= MOP_NONE;
      wen_q   <= 1'b0;     first_q <= 1'b0;   dout_q <= 1'b0;
      shreg_q <= '0;       bcnt_q <= '0;      ocnt_q <= '0;
      addr_q  <= '0;       dsr_q <= '0;       osr_q <= '0;
    end else begin
      mop_q <= MOP_NONE;
      if (s_fall) begin
        if (state_q == ST_ARMED) mop_q <= pend_q;
        state_q <= ST_IDLE;
        dout_q  <= 1'b0;
      end else if (s_rise) begin
        dout_q <= 1'b0;
        if (busy)       state_q <= ST_STATUS;
        else if (c_lvl) state_q <= ST_IGNORE;
        else            state_q <= ST_HUNT;
      end else begin
        unique case (state_q)
          ST_STATUS: begin
            dout_q <= ~busy;
            if (!busy && c_rise && d_lvl) begin
              state_q <= ST_CMD; bcnt_q <= '0; dout_q <= 1'b0;
            end
          end
          ST_HUNT: if (c_rise && d_lvl) begin state_q <= ST_CMD; bcnt_q <= '0; end
          ST_CMD: if (c_rise) begin
            shreg_q <= cmd_nxt[CMD_W-2:0];
            bcnt_q  <= bcnt_q + 1'b1;
            if (bcnt_q == aw_c + 1'b1) begin
              addr_q  <= dec_addr;
              bcnt_q  <= '0;
              state_q <= ST_IGNORE;
              unique case (dec_op)
                OPC_READ: begin
                  state_q <= ST_READ; first_q <= 1'b1; ocnt_q <= '0; dout_q <= 1'b0;
                end
                OPC_WRITE: if (wen_q) begin pend_q <= MOP_WRITE; state_q <= ST_DATA; end
                OPC_ERASE: if (wen_q) begin pend_q <= MOP_ERASE; state_q <= ST_ARMED; end
                default: unique case (dec_ext)
                  EXT_WEN:  wen_q <= 1'b1;
                  EXT_WDS:  wen_q <= 1'b0;
                  EXT_ERAL: if (wen_q) begin pend_q <= MOP_ERAL; state_q <= ST_ARMED; end
                  default:  if (wen_q) begin pend_q <= MOP_WRAL; state_q <= ST_DATA; end
                endcase
              endcase
            end
          end
          ST_DATA: if (c_rise) begin
            dsr_q  <= {dsr_q[WORD_W-2:0], d_lvl};
            bcnt_q <= bcnt_q + 1'b1;
            if (bcnt_q == dw_c - 1'b1) state_q <= ST_ARMED;
          end
          ST_ARMED: if (c_rise) state_q <= ST_IGNORE;
          ST_READ: if (c_rise) begin
            if (ocnt_q == '0) begin
              if (!first_q) addr_q <= addr_next;
              first_q <= 1'b0;
              osr_q   <= rd_data;
              dout_q  <= rd_data[dw_c-1'b1];
              ocnt_q  <= dw_c - 1'b1;
            end else begin
              dout_q <= osr_q[ocnt_q-1'b1];
              ocnt_q <= ocnt_q - 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign dout_o    = dout_q;
  assign dout_oe_o = s_lvl;
endmodule

// File: rtl/uw_core_checker.sv
module uw_core_checker import uw_pkg::*; (
  input logic      clk,
  input logic      rst_n,
  input uw_state_e state_i,
  input uw_mop_e   mop_i,
  input logic      busy_i,
  input logic      wen_i,
  input logic      s_lvl_i,
  input logic      dout_i
);
  p_prog_needs_wen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_i) |-> wen_i);

  p_no_decode_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> !(state_i inside {ST_HUNT, ST_CMD, ST_DATA, ST_ARMED, ST_READ}));

  p_status_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == ST_STATUS && $past(state_i == ST_STATUS && busy_i && s_lvl_i)) |-> !dout_i);

  p_op_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mop_i != MOP_NONE) |=> (mop_i == MOP_NONE && busy_i));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == ST_IDLE && $past(state_i) == ST_IDLE) |-> !dout_i);
endmodule

bind uwire_eeprom_core uw_core_checker u_chk (
  .clk(clk), .rst_n(rst_n), .state_i(state_q), .mop_i(mop_q),
  .busy_i(busy), .wen_i(wen_q), .s_lvl_i(s_lvl), .dout_i(dout_o)
);

// File: tb/sim_uwire_eeprom_core.sv
`timescale 1ns/1ps
module sim_uwire_eeprom_core;
  localparam int PROG = 200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel = 1'b0, sclk = 1'b0, din = 1'b0, org = 1'b1;
  logic dout, dout_oe;
  int   tests = 0, fails = 0;
  bit   done = 1'b0;
  logic [15:0] ref_mem [64];

  always #2.5 clk = ~clk;

  uwire_eeprom_core #(.PROG_CYCLES(PROG)) u0 (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .sclk_i(sclk), .din_i(din),
    .org_i(org), .dout_o(dout), .dout_oe_o(dout_oe));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model of the storage, written from the requirements.
  function automatic logic [15:0] ref_rd(input logic o, input logic [6:0] a);
    if (o) return ref_mem[a[5:0]];
    return a[0] ? {8'h00, ref_mem[a[6:1]][15:8]} : {8'h00, ref_mem[a[6:1]][7:0]};
  endfunction
  task automatic ref_wr(input logic o, input logic [6:0] a, input logic [15:0] d);
    if (o) ref_mem[a[5:0]] = d;
    else if (a[0]) ref_mem[a[6:1]][15:8] = d[7:0];
    else ref_mem[a[6:1]][7:0] = d[7:0];
  endtask
  task automatic ref_fill(input logic o, input logic [15:0] d);
    for (int i = 0; i < 64; i++) ref_mem[i] = ref_mem[i] & (o ? d : {2{d[7:0]}});
  endtask

  task automatic bitx(input logic d, output logic q);
    din = d;
    repeat (4) @(negedge clk); sclk = 1'b1;
    repeat (4) @(negedge clk); sclk = 1'b0;
    repeat (4) @(negedge clk); q = dout;
  endtask
  task automatic send(input logic [15:0] v, input int n, output logic q);
    for (int i = n - 1; i >= 0; i--) bitx(v[i], q);
  endtask
  task automatic sel_up();   sel = 1'b1; repeat (4) @(negedge clk); endtask
  task automatic sel_down(); sel = 1'b0; repeat (6) @(negedge clk); endtask
  task automatic wait_prog(); repeat (PROG + 12) @(negedge clk); endtask

  function automatic logic [6:0] ext_a(input logic o, input logic [1:0] e);
    return o ? {1'b0, e, 4'b0} : {e, 5'b0};
  endfunction

  task automatic issue(input logic o, input logic [1:0] op, input logic [6:0] a,
                       input logic [15:0] d, input int ndata, input int extra);
    logic q;
    org = o; sel_up();
    bitx(1'b1, q); send({14'b0, op}, 2, q); send({9'b0, a}, o ? 6 : 7, q);
    if (ndata > 0) send(d, ndata, q);
    for (int i = 0; i < extra; i++) bitx(1'b0, q);
    sel_down();
  endtask

  task automatic rd_chk(input logic o, input logic [6:0] a, input int n, input string tag);
    logic q; logic [15:0] v; logic [6:0] aa;
    int dw = o ? 16 : 8;
    org = o; sel_up();
    bitx(1'b1, q); send(16'b10, 2, q); send({9'b0, a}, o ? 6 : 7, q);
    chk(q == 1'b0, {tag, " R3 dummy zero"}, q, 0);
    aa = a;
    for (int w = 0; w < n; w++) begin
      v = '0;
      for (int b = 0; b < dw; b++) begin bitx(1'b0, q); v = {v[14:0], q}; end
      chk(v == ref_rd(o, aa), tag, v, ref_rd(o, aa));
      aa = o ? {1'b0, aa[5:0] + 6'd1} : aa + 7'd1;
    end
    sel_down();
  endtask

  task automatic t_reset();
    chk(dout == 1'b0 && dout_oe == 1'b0, "R10 reset pins", {dout, dout_oe}, 0);
    rd_chk(1'b1, 7'd0, 1, "R10 array all ones");
  endtask

  task automatic t_guard();
    issue(1'b1, 2'b01, 7'd3, 16'h1234, 16, 0); wait_prog();
    rd_chk(1'b1, 7'd3, 1, "R6 program ignored with latch clear");
  endtask

  task automatic t_write();
    issue(1'b1, 2'b00, ext_a(1'b1, 2'b11), 16'h0, 0, 0);
    issue(1'b1, 2'b01, 7'd5, 16'hA5C3, 16, 0); ref_wr(1'b1, 7'd5, 16'hA5C3); wait_prog();
    rd_chk(1'b1, 7'd5, 1, "R2 R7 word program and read");
  endtask

  task automatic t_byte();
    issue(1'b0, 2'b01, 7'd11, 16'h003C, 8, 0); ref_wr(1'b0, 7'd11, 16'h003C); wait_prog();
    rd_chk(1'b1, 7'd5, 1, "R5 byte 11 lands in word 5 upper half");
    rd_chk(1'b0, 7'd10, 1, "R5 byte 10 is word 5 lower half");
  endtask

  task automatic t_wrap();
    issue(1'b1, 2'b01, 7'd63, 16'h0F0F, 16, 0); ref_wr(1'b1, 7'd63, 16'h0F0F); wait_prog();
    issue(1'b1, 2'b01, 7'd0, 16'h1357, 16, 0);  ref_wr(1'b1, 7'd0, 16'h1357);  wait_prog();
    rd_chk(1'b1, 7'd63, 2, "R4 word view wrap 63 to 0");
    rd_chk(1'b0, 7'd127, 2, "R4 byte view wrap 127 to 0");
    rd_chk(1'b1, 7'd4, 2, "R4 stream 4 then 5");
  endtask

  task automatic t_erase();
    issue(1'b1, 2'b11, 7'd5, 16'h0, 0, 0); ref_mem[5] = 16'hFFFF; wait_prog();
    rd_chk(1'b1, 7'd5, 1, "R7 word erase");
    issue(1'b1, 2'b00, ext_a(1'b1, 2'b10), 16'h0, 0, 0);
    for (int i = 0; i < 64; i++) ref_mem[i] = 16'hFFFF;
    wait_prog();
    rd_chk(1'b1, 7'd62, 3, "R7 erase-all");
    issue(1'b1, 2'b00, ext_a(1'b1, 2'b01), 16'hF0F0, 16, 0); ref_fill(1'b1, 16'hF0F0); wait_prog();
    issue(1'b0, 2'b00, ext_a(1'b0, 2'b01), 16'h003C, 8, 0);  ref_fill(1'b0, 16'h003C); wait_prog();
    rd_chk(1'b1, 7'd40, 1, "R7 fill-all ANDs without erase");
    rd_chk(1'b0, 7'd81, 1, "R7 fill-all byte view");
  endtask

  task automatic t_cancel();
    issue(1'b1, 2'b01, 7'd9, 16'hABCD, 16, 1); wait_prog();
    rd_chk(1'b1, 7'd9, 1, "R8 extra clock cancels program");
    issue(1'b1, 2'b01, 7'd9, 16'hABCD, 10, 0); wait_prog();
    rd_chk(1'b1, 7'd9, 1, "R8 short frame cancels program");
    issue(1'b1, 2'b11, 7'd9, 16'h0, 0, 1); wait_prog();
    rd_chk(1'b1, 7'd9, 1, "R8 extra clock cancels erase");
  endtask

  task automatic t_start_rule();
    logic q; logic [15:0] v;
    org = 1'b1; sclk = 1'b1; sel = 1'b1; repeat (6) @(negedge clk);
    sclk = 1'b0; repeat (4) @(negedge clk);
    bitx(1'b1, q); send(16'b01, 2, q); send(16'd12, 6, q); send(16'h1111, 16, q);
    sel_down(); wait_prog();
    rd_chk(1'b1, 7'd12, 1, "R1 select rising with clock high ignored");
    sel_up(); bitx(1'b0, q); bitx(1'b0, q); bitx(1'b1, q);
    send(16'b10, 2, q); send(16'd5, 6, q);
    v = '0;
    for (int b = 0; b < 16; b++) begin bitx(1'b0, q); v = {v[14:0], q}; end
    chk(v == ref_mem[5], "R1 leading zeros before start bit", v, ref_mem[5]);
    sel_down();
  endtask

  task automatic t_status();
    logic q; int n;
    issue(1'b1, 2'b01, 7'd7, 16'h0000, 16, 0); ref_wr(1'b1, 7'd7, 16'h0000);
    sel_up();
    chk(dout == 1'b0 && dout_oe == 1'b1, "R9 busy reads 0", {dout, dout_oe}, 2'b01);
    bitx(1'b1, q); send(16'b00, 2, q); send({10'b0, ext_a(1'b1, 2'b00)}, 6, q);
    chk(q == 1'b0, "R9 still busy during ignored frame", q, 0);
    n = 0;
    while (dout !== 1'b1 && n < 1000) begin @(negedge clk); n++; end
    chk(dout == 1'b1, "R9 ready reads 1", dout, 1);
    bitx(1'b1, q);
    chk(q == 1'b0, "R9 start bit clears ready", q, 0);
    sel_down();
    issue(1'b1, 2'b01, 7'd8, 16'h4444, 16, 0); ref_wr(1'b1, 7'd8, 16'h4444); wait_prog();
    rd_chk(1'b1, 7'd8, 1, "R9 frame sent while busy had no effect");
    rd_chk(1'b1, 7'd7, 1, "R9 program under status poll");
    issue(1'b1, 2'b01, 7'd9, 16'h1111, 16, 0); ref_wr(1'b1, 7'd9, 16'h1111);
    sel = 1'b1; n = 0;
    while (dout !== 1'b1 && n < 1000) begin @(negedge clk); n++; end
    chk(n >= PROG - 6 && n <= PROG + 4, "R11 busy length", n, PROG);
    sel_down();
  endtask

  task automatic t_ewds();
    issue(1'b1, 2'b00, ext_a(1'b1, 2'b00), 16'h0, 0, 0);
    issue(1'b1, 2'b01, 7'd10, 16'h2222, 16, 0); wait_prog();
    rd_chk(1'b1, 7'd10, 1, "R6 latch closed blocks program, read still works");
    issue(1'b1, 2'b00, ext_a(1'b1, 2'b10), 16'h0, 0, 0); wait_prog();
    rd_chk(1'b1, 7'd9, 1, "R6 latch closed blocks erase-all");
  endtask

  initial begin
    for (int i = 0; i < 64; i++) ref_mem[i] = 16'hFFFF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset(); t_guard(); t_write(); t_byte(); t_wrap(); t_erase();
    t_cancel(); t_start_rule(); t_status(); t_ewds();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule